// File: doc/BRIEF.md
# Biharmonic Stencil Arithmetic Unit

This block evaluates the discretized fourth-order plate operator for one grid cell per clock. The caller presents the thirteen displacement samples of a diamond-shaped neighbourhood, which spans two cells in each axis direction, together with a signed scaling coefficient. The block forms the fixed-weight stencil sum with shifts and additions only. It then multiplies that sum by the coefficient in its one multiplier and returns a force term for the time-integration stage that follows.

The datapath is a three-register pipeline. Two registers belong to the adder tree and one to the multiply. A valid flag travels with each neighbourhood. The coefficient is captured in the same cycle as its neighbourhood, so a coefficient may change on every cycle. No bits are dropped and nothing is rounded. The stencil sum carries six guard bits above the state width, and the product is exactly the sum width plus the coefficient width. Generating the neighbourhood, applying boundary conditions and integrating over time belong to other blocks.

Top module: `biharm_stencil_unit`

## Requirements
- R1: Tap k occupies bits [k*STATE_W +: STATE_W] of `in_taps`. Tap 0 is the centre, taps 1..4 are the four axis neighbours at distance one, taps 5..8 are the four diagonal neighbours, and taps 9..12 are the four axis samples at distance two. For each accepted neighbourhood, `out_force` equals `in_coef` × (20·tap0 − 8·Σtaps1..4 + 2·Σtaps5..8 + Σtaps9..12), so a zero coefficient gives zero.
- R2: All arithmetic is two's-complement signed and exact. The stencil sum is STATE_W+6 bits and `out_force` is STATE_W+6+COEF_W bits. No input combination overflows or rounds, including any mix of the most negative and most positive state values and coefficients.
- R3: `out_valid` is high in exactly those cycles that come 3 clock edges after a cycle in which `in_valid` was high at an edge.
- R4: A new neighbourhood is accepted on every cycle. Back-to-back valid inputs produce back-to-back valid results in the same order.
- R5: The coefficient used for a result is the `in_coef` value sampled together with that result's neighbourhood. Coefficient changes in later cycles do not affect it.
- R6: A neighbourhood whose thirteen taps are all equal yields a result of zero for any tap value and any coefficient.
- R7: The synchronous active-high `rst` clears `out_valid` and `out_force` to zero at the next clock edge, and discards every result in flight.
- R8: When `out_valid` is low, `out_force` holds the value of the last valid result (zero after reset). Taps and coefficient presented with `in_valid` low have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Neighbourhood and coefficient are valid this cycle |
| in_taps | input | 13*STATE_W | Thirteen signed displacement taps, layout per R1 |
| in_coef | input | COEF_W | Signed scaling coefficient |
| out_valid | output | 1 | `out_force` carries a new result |
| out_force | output | STATE_W+6+COEF_W | Signed scaled stencil result |

## Verification
Three things can coincide in one cycle: a coefficient change, a new neighbourhood entering the adder tree, and an older result leaving the multiplier. The bench provokes this by streaming back-to-back neighbourhoods with a different coefficient on every cycle. Each result is judged against a bench model that pairs each neighbourhood with its own coefficient. Extreme taps are mixed into these streams, so the exactness checks and the pipelining checks fall in the same cycles. Gapped streams with garbage on idle cycles, plus a reset raised mid-stream, exercise the hold and flush rules against the same model.

// File: rtl/biharm_pkg.sv
package biharm_pkg;

    // Extra bits above the state width needed by the stencil sum
    localparam int GUARD_BITS  = 6;
    // Taps in the diamond neighbourhood: centre plus three rings of four
    localparam int NUM_TAPS    = 13;
    localparam int RING_TAPS   = 4;
    localparam int NUM_RINGS   = 3;
    // Bits gained by adding four taps of one ring
    localparam int RING_GROWTH = 2;

    typedef enum logic [1:0] {
        RING_NEAR = 2'd0,   // axis neighbours at distance one, weight -8
        RING_DIAG = 2'd1,   // diagonal neighbours, weight +2
        RING_FAR  = 2'd2    // axis samples at distance two, weight +1
    } ring_e;

    // Index of the first tap of a ring within the flattened tap vector
    function automatic int ring_first_tap(int ring);
        return 1 + RING_TAPS * ring;
    endfunction

    // Left-shift amount that realises the magnitude of a ring weight
    function automatic int ring_shift(int ring);
        case (ring)
            0:       return 3;
            1:       return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/biharm_ring_stage.sv
// Stage 1: centre term x20 by two shifts, and a plain sum of each ring.
module biharm_ring_stage
    import biharm_pkg::*;
#(
    parameter int STATE_W = 36,
    parameter int COEF_W  = 18,
    parameter int SUM_W   = STATE_W + GUARD_BITS,
    parameter int RING_W  = STATE_W + RING_GROWTH
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic [NUM_TAPS*STATE_W-1:0]     in_taps,
    input  logic signed [COEF_W-1:0]        in_coef,
    output logic                            s1_valid,
    output logic signed [SUM_W-1:0]         s1_centre20,
    output logic signed [RING_W-1:0]        s1_near,
    output logic signed [RING_W-1:0]        s1_diag,
    output logic signed [RING_W-1:0]        s1_far,
    output logic signed [COEF_W-1:0]        s1_coef
);

    logic signed [STATE_W-1:0] tap      [NUM_TAPS];
    logic signed [RING_W-1:0]  ring_sum [NUM_RINGS];
    logic signed [SUM_W-1:0]   centre_ext;
    logic signed [SUM_W-1:0]   centre20;

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_unpack
        assign tap[t] = in_taps[t*STATE_W +: STATE_W];
    end

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        localparam int FIRST = ring_first_tap(r);
        logic signed [RING_W-1:0] acc;
        always_comb begin
            acc = '0;
            for (int k = 0; k < RING_TAPS; k++) begin
                acc = acc + RING_W'(tap[FIRST+k]);
            end
        end
        assign ring_sum[r] = acc;
    end

    // 20x = 16x + 4x
    assign centre_ext = SUM_W'(tap[0]);
    assign centre20   = (centre_ext <<< 4) + (centre_ext <<< 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid    <= 1'b0;
            s1_centre20 <= '0;
            s1_near     <= '0;
            s1_diag     <= '0;
            s1_far      <= '0;
            s1_coef     <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_centre20 <= centre20;
                s1_near     <= ring_sum[RING_NEAR];
                s1_diag     <= ring_sum[RING_DIAG];
                s1_far      <= ring_sum[RING_FAR];
                s1_coef     <= in_coef;
            end
        end
    end

endmodule

// File: rtl/biharm_combine_stage.sv
// Stage 2: apply ring weights by shifting and fold into one stencil sum.
module biharm_combine_stage
    import biharm_pkg::*;
#(
    parameter int STATE_W = 36,
    parameter int COEF_W  = 18,
    parameter int SUM_W   = STATE_W + GUARD_BITS,
    parameter int RING_W  = STATE_W + RING_GROWTH
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      s1_valid,
    input  logic signed [SUM_W-1:0]   s1_centre20,
    input  logic signed [RING_W-1:0]  s1_near,
    input  logic signed [RING_W-1:0]  s1_diag,
    input  logic signed [RING_W-1:0]  s1_far,
    input  logic signed [COEF_W-1:0]  s1_coef,
    output logic                      s2_valid,
    output logic signed [SUM_W-1:0]   s2_sum,
    output logic signed [COEF_W-1:0]  s2_coef
);

    typedef struct packed {
        logic signed [SUM_W-1:0] near_w;   // magnitude of the -8 ring
        logic signed [SUM_W-1:0] diag_w;   // +2 ring
        logic signed [SUM_W-1:0] far_w;    // +1 ring
    } weighted_t;

    weighted_t               wt;
    logic signed [SUM_W-1:0] stencil;

    always_comb begin
        wt.near_w = SUM_W'(s1_near) <<< ring_shift(int'(RING_NEAR));
        wt.diag_w = SUM_W'(s1_diag) <<< ring_shift(int'(RING_DIAG));
        wt.far_w  = SUM_W'(s1_far)  <<< ring_shift(int'(RING_FAR));
        stencil   = s1_centre20 - wt.near_w + wt.diag_w + wt.far_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            s2_sum   <= '0;
            s2_coef  <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_sum  <= stencil;
                s2_coef <= s1_coef;
            end
        end
    end

endmodule

// File: rtl/biharm_scale_stage.sv
// Stage 3: the single multiplier, full-width signed product.
module biharm_scale_stage
    import biharm_pkg::*;
#(
    parameter int STATE_W = 36,
    parameter int COEF_W  = 18,
    parameter int SUM_W   = STATE_W + GUARD_BITS,
    parameter int OUT_W   = SUM_W + COEF_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      s2_valid,
    input  logic signed [SUM_W-1:0]   s2_sum,
    input  logic signed [COEF_W-1:0]  s2_coef,
    output logic                      out_valid,
    output logic signed [OUT_W-1:0]   out_force
);

    logic signed [OUT_W-1:0] product;

    assign product = OUT_W'(s2_sum) * OUT_W'(s2_coef);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_force <= '0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) begin
                out_force <= product;
            end
        end
    end

endmodule

// File: rtl/biharm_stencil_unit.sv
module biharm_stencil_unit
    import biharm_pkg::*;
#(
    parameter int STATE_W = 36,
    parameter int COEF_W  = 18
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     in_valid,
    input  logic [NUM_TAPS*STATE_W-1:0]              in_taps,
    input  logic signed [COEF_W-1:0]                 in_coef,
    output logic                                     out_valid,
    output logic signed [STATE_W+GUARD_BITS+COEF_W-1:0] out_force
);

    localparam int SUM_W  = STATE_W + GUARD_BITS;
    localparam int RING_W = STATE_W + RING_GROWTH;
    localparam int OUT_W  = SUM_W + COEF_W;

    logic                     s1_valid;
    logic signed [SUM_W-1:0]  s1_centre20;
    logic signed [RING_W-1:0] s1_near;
    logic signed [RING_W-1:0] s1_diag;
    logic signed [RING_W-1:0] s1_far;
    logic signed [COEF_W-1:0] s1_coef;
    logic                     s2_valid;
    logic signed [SUM_W-1:0]  s2_sum;
    logic signed [COEF_W-1:0] s2_coef;

    biharm_ring_stage #(
        .STATE_W(STATE_W), .COEF_W(COEF_W), .SUM_W(SUM_W), .RING_W(RING_W)
    ) ring_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_taps(in_taps),
        .in_coef(in_coef), .s1_valid(s1_valid), .s1_centre20(s1_centre20),
        .s1_near(s1_near), .s1_diag(s1_diag), .s1_far(s1_far), .s1_coef(s1_coef)
    );

    biharm_combine_stage #(
        .STATE_W(STATE_W), .COEF_W(COEF_W), .SUM_W(SUM_W), .RING_W(RING_W)
    ) combine_i (
        .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_centre20(s1_centre20),
        .s1_near(s1_near), .s1_diag(s1_diag), .s1_far(s1_far), .s1_coef(s1_coef),
        .s2_valid(s2_valid), .s2_sum(s2_sum), .s2_coef(s2_coef)
    );

    biharm_scale_stage #(
        .STATE_W(STATE_W), .COEF_W(COEF_W), .SUM_W(SUM_W), .OUT_W(OUT_W)
    ) scale_i (
        .clk(clk), .rst(rst), .s2_valid(s2_valid), .s2_sum(s2_sum),
        .s2_coef(s2_coef), .out_valid(out_valid), .out_force(out_force)
    );

endmodule

// File: rtl/biharm_stencil_unit_chk.sv
module biharm_stencil_unit_chk
    import biharm_pkg::*;
#(
    parameter int STATE_W = 36,
    parameter int COEF_W  = 18,
    parameter int OUT_W   = STATE_W + GUARD_BITS + COEF_W
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         in_valid,
    input logic [NUM_TAPS*STATE_W-1:0]  in_taps,
    input logic signed [COEF_W-1:0]     in_coef,
    input logic                         out_valid,
    input logic signed [OUT_W-1:0]      out_force
);

    // Edges since reset release, saturating at the pipeline depth
    logic [1:0] settle;
    logic       flat_nb;
    logic       coef_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            settle <= 2'd0;
        end else if (settle != 2'd3) begin
            settle <= settle + 2'd1;
        end
    end

    always_comb begin
        flat_nb = 1'b1;
        for (int i = 1; i < NUM_TAPS; i++) begin
            if (in_taps[i*STATE_W +: STATE_W] != in_taps[0 +: STATE_W]) begin
                flat_nb = 1'b0;
            end
        end
    end

    assign coef_zero = (in_coef == '0);

    assert_valid_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (settle == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_flat_gives_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (settle == 2'd3 && $past(in_valid, 3) && $past(flat_nb, 3)) |-> (out_force == '0));

    assert_zero_coef_R1: assert property (@(posedge clk) disable iff (rst)
        (settle == 2'd3 && $past(in_valid, 3) && $past(coef_zero, 3)) |-> (out_force == '0));

    assert_reset_clears_R7: assert property (@(posedge clk)
        rst |=> (!out_valid && out_force == '0));

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (settle != 2'd0 && !out_valid) |-> $stable(out_force));

endmodule

bind biharm_stencil_unit biharm_stencil_unit_chk #(
    .STATE_W(STATE_W), .COEF_W(COEF_W)
) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_taps(in_taps),
    .in_coef(in_coef), .out_valid(out_valid), .out_force(out_force)
);

// File: tb/biharm_stencil_unit_tb_top.sv
module biharm_stencil_unit_tb_top;

    localparam int SW = 36;
    localparam int CW = 18;
    localparam int NT = 13;
    localparam int OW = SW + 6 + CW;

    typedef logic signed [SW-1:0] tap_arr_t [NT];

    localparam logic signed [SW-1:0] S_MIN = {1'b1, {(SW-1){1'b0}}};
    localparam logic signed [SW-1:0] S_MAX = {1'b0, {(SW-1){1'b1}}};
    localparam logic signed [CW-1:0] C_MIN = {1'b1, {(CW-1){1'b0}}};
    localparam logic signed [CW-1:0] C_MAX = {1'b0, {(CW-1){1'b1}}};

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic                 rst;
    logic                 in_valid;
    logic [NT*SW-1:0]     in_taps;
    logic signed [CW-1:0] in_coef;
    logic                 out_valid;
    logic signed [OW-1:0] out_force;

    int n_checks = 0;
    int n_fail   = 0;

    tap_arr_t t;

    // Expected-output model: three entries in flight, newest at index 0
    logic                 h_v   [3];
    logic signed [OW-1:0] h_d   [3];
    string                h_tag [3];
    logic                 exp_v;
    logic signed [OW-1:0] exp_f;
    string                exp_tag;

    biharm_stencil_unit #(.STATE_W(SW), .COEF_W(CW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_taps(in_taps),
        .in_coef(in_coef), .out_valid(out_valid), .out_force(out_force)
    );

    function automatic logic signed [OW-1:0] ref_force(tap_arr_t v, logic signed [CW-1:0] c);
        longint s;
        longint p;
        s = 20 * longint'(v[0]);
        for (int i = 1; i <= 4; i++)  s = s - 8 * longint'(v[i]);
        for (int i = 5; i <= 8; i++)  s = s + 2 * longint'(v[i]);
        for (int i = 9; i <= 12; i++) s = s + longint'(v[i]);
        p = s * longint'(c);
        return p[OW-1:0];
    endfunction

    function automatic logic signed [SW-1:0] rnd_state();
        logic [63:0] r;
        r = {$urandom(), $urandom()};
        case ($urandom() % 8)
            0:       return S_MIN;
            1:       return S_MAX;
            default: return r[SW-1:0];
        endcase
    endfunction

    function automatic logic signed [CW-1:0] rnd_coef();
        logic [31:0] r;
        r = $urandom();
        case (r % 8)
            0:       return C_MIN;
            1:       return C_MAX;
            default: return r[CW+7:8];
        endcase
    endfunction

    task automatic clear_taps();
        for (int i = 0; i < NT; i++) t[i] = '0;
    endtask

    task automatic rand_taps();
        for (int i = 0; i < NT; i++) t[i] = rnd_state();
    endtask

    // One clock: drive at the falling edge, model at the rising edge, check at the next falling edge
    task automatic step(string tag);
        for (int i = 0; i < NT; i++) in_taps[i*SW +: SW] = t[i];
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                h_v[i] = 1'b0; h_d[i] = '0; h_tag[i] = "R7";
            end
            exp_v = 1'b0; exp_f = '0; exp_tag = "R7";
        end else begin
            h_v[2] = h_v[1]; h_d[2] = h_d[1]; h_tag[2] = h_tag[1];
            h_v[1] = h_v[0]; h_d[1] = h_d[0]; h_tag[1] = h_tag[0];
            h_v[0] = in_valid; h_d[0] = ref_force(t, in_coef); h_tag[0] = tag;
            exp_v = h_v[2];
            if (h_v[2]) begin
                exp_f = h_d[2]; exp_tag = h_tag[2];
            end else begin
                exp_tag = "R8";
            end
        end
        @(negedge clk);
        n_checks++;
        if (out_valid !== exp_v) begin
            n_fail++;
            $display("FAIL R3: out_valid=%0b expected %0b", out_valid, exp_v);
        end
        n_checks++;
        if (out_force !== exp_f) begin
            n_fail++;
            $display("FAIL %s: out_force=%0d expected %0d", exp_tag, out_force, exp_f);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R4: watchdog expired, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0b1a));
        rst = 1'b1; in_valid = 1'b0; in_coef = '0; clear_taps();
        @(negedge clk);
        repeat (4) step("R7");            // reset state
        rst = 1'b0;
        repeat (3) step("R8");

        // R1: one tap per ring, unit impulses
        in_valid = 1'b1; in_coef = 18'sd1;
        clear_taps(); t[0] = 1;  step("R1");   // 20
        clear_taps(); t[2] = 1;  step("R1");   // -8
        clear_taps(); t[6] = 1;  step("R1");   // 2
        clear_taps(); t[11] = 1; step("R1");   // 1
        clear_taps(); t[0] = 5; in_coef = -18'sd3; step("R1");  // -300
        rand_taps(); in_coef = '0; step("R1");                  // zero coefficient

        // R6: flat neighbourhoods
        for (int i = 0; i < NT; i++) t[i] = S_MIN;
        in_coef = C_MAX; step("R6");
        for (int i = 0; i < NT; i++) t[i] = S_MAX;
        in_coef = C_MIN; step("R6");

        // R2: worst-case magnitudes in both directions
        t[0] = S_MAX;
        for (int i = 1; i <= 4; i++)  t[i] = S_MIN;
        for (int i = 5; i <= 12; i++) t[i] = S_MAX;
        in_coef = C_MIN; step("R2");
        t[0] = S_MIN;
        for (int i = 1; i <= 4; i++)  t[i] = S_MAX;
        for (int i = 5; i <= 12; i++) t[i] = S_MIN;
        in_coef = C_MIN; step("R2");
        in_coef = C_MAX; step("R2");

        // R5: same neighbourhood, coefficient changes every cycle
        rand_taps();
        in_coef = 18'sd1;  step("R5");
        in_coef = 18'sd2;  step("R5");
        in_coef = -18'sd1; step("R5");
        in_coef = 18'sd0;  step("R5");
        in_coef = C_MIN;   step("R5");

        // R4: back-to-back random stream with per-cycle coefficients
        for (int n = 0; n < 3000; n++) begin
            rand_taps(); in_coef = rnd_coef(); step("R4");
        end

        // R3 and R8: gapped stream, garbage on idle cycles
        for (int n = 0; n < 3000; n++) begin
            in_valid = ($urandom() % 3) != 0;
            rand_taps(); in_coef = rnd_coef();
            step(in_valid ? "R3" : "R8");
        end

        // R7: reset with results in flight
        in_valid = 1'b1;
        for (int n = 0; n < 3; n++) begin
            rand_taps(); in_coef = rnd_coef(); step("R4");
        end
        rst = 1'b1;
        repeat (2) step("R7");
        rst = 1'b0; in_valid = 1'b0;
        repeat (5) begin
            rand_taps(); step("R8");
        end

        summary();
        $finish;
    end

endmodule